// File: doc/BRIEF.md
# Five-phase eleven-segment large/medium vector sequencer

This block drives the five upper switches of one five-phase two-level inverter leg set, and gives each its complementary lower command. Each sampling period uses two neighbouring large vectors, two neighbouring medium vectors and the two null states. A controller supplies the sector, two combined active dwell times, the period length in clock cycles and the large-vector share of each dwell. It loads all of these with one sample strobe. The block splits each combined dwell into a large part and a medium part with a multiply and a shift, so no divider is needed. It derives the null time, then plays eleven segments that mirror about a centre all-ones state.

The switch states climb from no leg high to all legs high, one leg per segment, and then fall back the same way. At every boundary between non-empty segments only one leg changes. The ramp of states for a sector is a rotation of one of two base ramps, one for odd sectors and one for even sectors. The trigonometry that produces the dwell times, the dead time and the power stage sit outside this block.

Top module: `svm5_seq`

## Requirements
- R1: All inputs are captured on the clock edge where `smp_stb` is high. Changes to the inputs between strobes do not affect the outputs. A strobe during a running period restarts the sequence at segment 0 on the next cycle.
- R2: Each combined dwell T is split into a large part floor(T·`lg_share`/2^SH_W) and a medium part T minus the large part. The default `lg_share` is 158, which is about 1/(1+1/1.618).
- R3: The null time is Z = `period` − `dwell_a` − `dwell_b`. Segments 0 and 10 each last floor(Z/4) cycles and segment 5 lasts Z − 2·floor(Z/4) cycles.
- R4: Segments 0 to 10 hold these states in order: null, 1-one, 2-one, 3-one, 4-one, all-ones, 4-one, 3-one, 2-one, 1-one, null. The 1-one and 3-one states use the medium and large parts of `dwell_a`. The 2-one and 4-one states use the large and medium parts of `dwell_b`. Segment k begins one cycle after the strobe plus the summed lengths of segments 0 to k−1.
- R5: `gate_hi` bit 4 is phase a and bit 0 is phase e. Sector 1 ramps through 10000, 11000, 11001, 11101. Sector 2 ramps through 01000, 11000, 11100, 11101. Sector 2m+1 is the sector-1 ramp rotated right by m places, and sector 2m+2 is the sector-2 ramp rotated right by m places.
- R6: A segment of zero length is skipped. After segment 10, `gate_hi` stays 00000 until the next strobe.
- R7: A latched sector outside 1 to 10 holds `gate_hi` at 00000 for the whole period.
- R8: When `dwell_a`+`dwell_b` exceeds `period`, the null time is clamped to zero and `ovm` is 1 until the next strobe. Otherwise `ovm` is 0. Equality is not overmodulation.
- R9: `gate_lo` is the bitwise complement of `gate_hi` at all times.
- R10: After reset and before the first strobe, `gate_hi` is 00000, `gate_lo` is 11111 and `ovm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; loads all other inputs |
| sector | input | 4 | Sector number, valid 1 to 10 |
| dwell_a | input | T_W | Combined dwell of the first vector pair, in cycles |
| dwell_b | input | T_W | Combined dwell of the second vector pair, in cycles |
| period | input | T_W | Sampling period, in cycles |
| lg_share | input | SH_W | Large-vector fraction of each dwell, unsigned fixed point |
| gate_hi | output | 5 | Upper-switch commands, bit 4 = phase a |
| gate_lo | output | 5 | Lower-switch commands, complement of `gate_hi` |
| ovm | output | 1 | Overmodulation flag for the current period |

## Verification
Two functions can land in the same cycle. The first case is a fresh strobe arriving while the previous period is still mid-ramp, so the restart and the running segment count compete for the same cycle. The bench provokes it by cutting one period short after a few cycles and checking that the very next sample shows segment 0 of the new sector. The second case is the null clamp falling together with segment skipping: an overmodulated or exactly saturated period leaves the null segments empty, and a share of 0 empties the large segments. The bench checks that the output jumps straight over the empty segments, with cycle-exact edges computed arithmetically from the dwell values.

// File: rtl/svm5_pkg.sv
package svm5_pkg;

    localparam int LEGS   = 5;
    localparam int NSEG   = 11;
    localparam int NSECT  = 10;
    localparam int SEG_W  = 4;
    localparam int SEC_W  = 4;

    typedef logic [LEGS-1:0]  leg_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [SEC_W-1:0] sec_t;

    // switch states of one half-period, by number of legs high
    typedef struct packed {
        leg_t one;
        leg_t two;
        leg_t three;
        leg_t four;
    } ramp_t;

    typedef enum logic [1:0] {
        KIND_NULL,
        KIND_FULL,
        KIND_RISE,
        KIND_FALL
    } seg_kind_e;

    localparam ramp_t RAMP_ODD  = '{5'b10000, 5'b11000, 5'b11001, 5'b11101};
    localparam ramp_t RAMP_EVEN = '{5'b01000, 5'b11000, 5'b11100, 5'b11101};

    // about |vl|/(|vl|+|vm|) with |vl|/|vm| = 1.618, in Q0.8
    localparam logic [7:0] SHARE_GOLDEN_Q8 = 8'd158;

    function automatic logic sector_ok(input sec_t s);
        return (s >= sec_t'(1)) && (s <= sec_t'(NSECT));
    endfunction

    function automatic leg_t rot_r(input leg_t v, input logic [2:0] n);
        leg_t r;
        r = v;
        for (int i = 0; i < LEGS; i++) begin
            if (i < int'(n)) r = {r[0], r[LEGS-1:1]};
        end
        return r;
    endfunction

    function automatic ramp_t sector_ramp(input sec_t s);
        sec_t  m;
        ramp_t b;
        ramp_t r;
        m = (s - sec_t'(1)) >> 1;
        b = s[0] ? RAMP_ODD : RAMP_EVEN;
        r.one   = rot_r(b.one,   m[2:0]);
        r.two   = rot_r(b.two,   m[2:0]);
        r.three = rot_r(b.three, m[2:0]);
        r.four  = rot_r(b.four,  m[2:0]);
        return r;
    endfunction

    function automatic seg_kind_e seg_kind(input seg_t g);
        if (g == seg_t'(5))                          return KIND_FULL;
        if (g >= seg_t'(1) && g <= seg_t'(4))        return KIND_RISE;
        if (g >= seg_t'(6) && g <= seg_t'(9))        return KIND_FALL;
        return KIND_NULL;
    endfunction

endpackage

// File: rtl/svm5_dwell_split.sv
module svm5_dwell_split
    import svm5_pkg::*;
#(
    parameter int T_W  = 12,
    parameter int SH_W = 8
) (
    input  logic [T_W-1:0]             ta,
    input  logic [T_W-1:0]             tb,
    input  logic [T_W-1:0]             ts,
    input  logic [SH_W-1:0]            share,
    output logic [NSEG-1:0][T_W-1:0]   dur,
    output logic                       over
);
    localparam int P_W = T_W + SH_W;

    logic [T_W-1:0] tal, tam, tbl, tbm, z, zq, zc;
    logic [T_W:0]   sum_ab;

    always_comb begin
        tal    = T_W'((P_W'(ta) * P_W'(share)) >> SH_W);
        tbl    = T_W'((P_W'(tb) * P_W'(share)) >> SH_W);
        tam    = ta - tal;
        tbm    = tb - tbl;
        sum_ab = {1'b0, ta} + {1'b0, tb};
        over   = sum_ab > {1'b0, ts};
        z      = over ? '0 : (ts - sum_ab[T_W-1:0]);
        zq     = z >> 2;
        zc     = z - (zq << 1);
    end

    always_comb begin
        dur[0] = zq;
        dur[1] = tam;
        dur[2] = tbl;
        dur[3] = tal;
        dur[4] = tbm;
        dur[5] = zc;
        for (int i = 1; i <= 4; i++) dur[NSEG-1-i] = dur[i];
        dur[NSEG-1] = zq;
    end

    always_comb begin
        assert (over || (32'(tam) + 32'(tal) + 32'(tbm) + 32'(tbl) + 32'(zq) * 2 + 32'(zc) == 32'(ts)))
            else $error("AST_SPLIT_FILLS_PERIOD"); // R3
    end

endmodule

// File: rtl/svm5_seg_clock.sv
module svm5_seg_clock
    import svm5_pkg::*;
#(
    parameter int D_W = 12,
    localparam int B_W = D_W + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [NSEG-1:0][D_W-1:0]  dur,
    output seg_t                      seg,
    output logic                      run
);
    logic [NSEG-1:0][B_W-1:0] acc, bnd;
    logic [B_W-1:0]           tcnt;

    always_comb begin
        logic [B_W-1:0] sum;
        sum = '0;
        for (int i = 0; i < NSEG; i++) begin
            sum    = sum + B_W'(dur[i]);
            acc[i] = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd  <= '0;
            tcnt <= '0;
            run  <= 1'b0;
        end else if (load) begin
            bnd  <= acc;
            tcnt <= '0;
            run  <= 1'b1;
        end else if (run && (tcnt < bnd[NSEG-1])) begin
            tcnt <= tcnt + B_W'(1);
        end
    end

    // segment index = number of segment ends already passed
    always_comb begin
        seg_t cnt;
        cnt = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (tcnt >= bnd[i]) cnt = cnt + seg_t'(1);
        end
        seg = cnt;
    end

    AST_CNT_BOUND:    assert property (@(posedge clk) disable iff (rst)
                          run |-> (tcnt <= bnd[NSEG-1])) else $error("cnt bound"); // R6
    AST_OUTER_EQUAL:  assert property (@(posedge clk) disable iff (rst)
                          run |-> ((bnd[NSEG-1] - bnd[NSEG-2]) == bnd[0])) else $error("outer"); // R3
    AST_MIRROR:       assert property (@(posedge clk) disable iff (rst)
                          run |-> ((bnd[6] - bnd[5]) == (bnd[4] - bnd[3]))) else $error("mirror"); // R4
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
                          load |=> (tcnt == '0 && run)) else $error("restart"); // R1

endmodule

// File: rtl/svm5_leg_map.sv
module svm5_leg_map
    import svm5_pkg::*;
(
    input  sec_t  sector,
    input  seg_t  seg,
    input  logic  run,
    output leg_t  legs
);
    ramp_t     r;
    seg_kind_e k;
    leg_t      pick;

    always_comb begin
        r = sector_ramp(sector);
        k = seg_kind(seg);
        unique case (k)
            KIND_FULL: pick = '1;
            KIND_RISE: begin
                case (seg)
                    seg_t'(1): pick = r.one;
                    seg_t'(2): pick = r.two;
                    seg_t'(3): pick = r.three;
                    default:   pick = r.four;
                endcase
            end
            KIND_FALL: begin
                case (seg)
                    seg_t'(6): pick = r.four;
                    seg_t'(7): pick = r.three;
                    seg_t'(8): pick = r.two;
                    default:   pick = r.one;
                endcase
            end
            default:   pick = '0;
        endcase
        legs = (run && sector_ok(sector)) ? pick : '0;
    end

endmodule

// File: rtl/svm5_seq.sv
module svm5_seq
    import svm5_pkg::*;
#(
    parameter int T_W  = 12,
    parameter int SH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_stb,
    input  logic [3:0]      sector,
    input  logic [T_W-1:0]  dwell_a,
    input  logic [T_W-1:0]  dwell_b,
    input  logic [T_W-1:0]  period,
    input  logic [SH_W-1:0] lg_share,
    output logic [4:0]      gate_hi,
    output logic [4:0]      gate_lo,
    output logic            ovm
);
    logic [NSEG-1:0][T_W-1:0] dur;
    logic                     over_now;
    sec_t                     sector_q;
    logic                     over_q;
    seg_t                     seg;
    logic                     run;
    leg_t                     legs;

    svm5_dwell_split #(.T_W(T_W), .SH_W(SH_W)) u_split (
        .ta    (dwell_a),
        .tb    (dwell_b),
        .ts    (period),
        .share (lg_share),
        .dur   (dur),
        .over  (over_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sector_q <= '0;
            over_q   <= 1'b0;
        end else if (smp_stb) begin
            sector_q <= sector;
            over_q   <= over_now;
        end
    end

    svm5_seg_clock #(.D_W(T_W)) u_clock (
        .clk  (clk),
        .rst  (rst),
        .load (smp_stb),
        .dur  (dur),
        .seg  (seg),
        .run  (run)
    );

    svm5_leg_map u_map (
        .sector (sector_q),
        .seg    (seg),
        .run    (run),
        .legs   (legs)
    );

    assign gate_hi = legs;
    assign gate_lo = ~legs;
    assign ovm     = over_q;

    AST_BAD_SECTOR: assert property (@(posedge clk) disable iff (rst)
                        !sector_ok(sector_q) |-> (gate_hi == '0)) else $error("bad sector"); // R7
    AST_IDLE_LOW:   assert property (@(posedge clk) disable iff (rst)
                        !run |-> (gate_hi == '0 && !ovm)) else $error("idle"); // R10
    AST_OVM_HELD:   assert property (@(posedge clk) disable iff (rst)
                        !smp_stb |=> $stable(ovm)) else $error("ovm held"); // R8
    AST_CENTER_ALL: assert property (@(posedge clk) disable iff (rst)
                        (run && sector_ok(sector_q) && seg == seg_t'(5)) |-> (gate_hi == '1)) else $error("centre"); // R4

endmodule

// File: tb/svm5_seq_test.sv
`timescale 1ns/1ps
module svm5_seq_test;
    localparam int T_W  = 12;
    localparam int SH_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            smp_stb = 1'b0;
    logic [3:0]      sector = '0;
    logic [T_W-1:0]  dwell_a = '0, dwell_b = '0, period = '0;
    logic [SH_W-1:0] lg_share = '0;
    logic [4:0]      gate_hi, gate_lo;
    logic            ovm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    svm5_seq #(.T_W(T_W), .SH_W(SH_W)) uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .sector(sector),
        .dwell_a(dwell_a), .dwell_b(dwell_b), .period(period),
        .lg_share(lg_share), .gate_hi(gate_hi), .gate_lo(gate_lo), .ovm(ovm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ramp states per sector (R5): bit 4 = phase a
    function automatic logic [4:0] ramp_state(input int sec, input int k);
        logic [19:0] row;
        case (sec)
            1:  row = 20'b10000_11000_11001_11101;
            2:  row = 20'b01000_11000_11100_11101;
            3:  row = 20'b01000_01100_11100_11110;
            4:  row = 20'b00100_01100_01110_11110;
            5:  row = 20'b00100_00110_01110_01111;
            6:  row = 20'b00010_00110_00111_01111;
            7:  row = 20'b00010_00011_00111_10111;
            8:  row = 20'b00001_00011_10011_10111;
            9:  row = 20'b00001_10001_10011_11011;
            default: row = 20'b10000_10001_11001_11011;
        endcase
        return row[19-5*(k-1) -: 5];
    endfunction

    function automatic logic [4:0] exp_legs(input int sec, input int seg);
        if (sec < 1 || sec > 10) return 5'b00000;
        if (seg == 5) return 5'b11111;
        if (seg >= 1 && seg <= 4) return ramp_state(sec, seg);
        if (seg >= 6 && seg <= 9) return ramp_state(sec, 10 - seg);
        return 5'b00000;
    endfunction

    task automatic run_case(input int sec, input int ta, input int tb, input int ts,
                            input int sh, input int maxc, input string req);
        int d[11];
        int tal, tam, tbl, tbm, z, zq, total, lim;
        bit over;
        tal = (ta * sh) >> SH_W;  tam = ta - tal;    // R2
        tbl = (tb * sh) >> SH_W;  tbm = tb - tbl;
        over = (ta + tb) > ts;                       // R8
        z  = over ? 0 : ts - ta - tb;                // R3
        zq = z / 4;
        d[0] = zq; d[1] = tam; d[2] = tbl; d[3] = tal; d[4] = tbm;
        d[5] = z - 2 * zq;
        d[6] = tbm; d[7] = tal; d[8] = tbl; d[9] = tam; d[10] = zq;
        total = 0;
        for (int i = 0; i < 11; i++) total += d[i];
        @(negedge clk);
        sector = 4'(sec); dwell_a = T_W'(ta); dwell_b = T_W'(tb);
        period = T_W'(ts); lg_share = SH_W'(sh); smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        // R1: scramble inputs while the period runs
        sector = 4'(sec ^ 5); dwell_a = ~dwell_a; dwell_b = T_W'(3);
        period = T_W'(1); lg_share = ~lg_share;
        lim = (maxc < total + 3) ? maxc : total + 3;
        for (int t = 0; t < lim; t++) begin
            int seg, acc;
            logic [4:0] e;
            seg = 11; acc = 0;
            for (int i = 0; i < 11; i++) begin
                acc += d[i];
                if (seg == 11 && t < acc) seg = i;
            end
            e = exp_legs(sec, seg);
            check(gate_hi == e, req, int'(gate_hi), int'(e));
            check(gate_lo == ~gate_hi, "R9", int'(gate_lo), int'(~gate_hi));
            check(ovm == over, "R8", int'(ovm), int'(over));
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(gate_hi == 5'b00000, "R10", int'(gate_hi), 0);
        check(gate_lo == 5'b11111, "R10", int'(gate_lo), 31);
        check(ovm == 1'b0, "R10", int'(ovm), 0);

        for (int s = 1; s <= 10; s++) run_case(s, 10, 14, 40, 158, 999, "R5");
        for (int s = 1; s <= 10; s++) run_case(s, 9, 6, 30, 158, 999, "R3");
        run_case(0,  10, 14, 40, 158, 999, "R7");
        run_case(11, 10, 14, 40, 158, 999, "R7");
        run_case(15, 10, 14, 40, 158, 999, "R7");
        run_case(3, 20, 12, 50, 0,   999, "R2");   // empty large segments (R6)
        run_case(4, 20, 12, 50, 255, 999, "R2");
        run_case(6, 17, 11, 60, 158, 999, "R2");
        run_case(2, 30, 25, 40, 158, 999, "R8");   // overmodulated
        run_case(7, 20, 20, 40, 158, 999, "R8");   // exact fill, no flag
        run_case(5, 0, 0, 20, 158, 999, "R6");     // only null and full
        run_case(1, 0, 0, 0, 158, 999, "R6");      // nothing at all
        run_case(8, 10, 14, 40, 158, 7, "R1");     // cut short
        run_case(9, 10, 14, 40, 158, 999, "R1");   // restart mid-period
        run_case(10, 31, 5, 44, 158, 999, "R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule